// File: doc/BRIEF.md
# Skip-Bad-Block Partition Mapper

This block plans how a factory image is laid onto a raw NAND device whose bad blocks are skipped. It is given a table of partitions. Each entry has a physical first block, a physical last block and the number of good blocks the partition's image needs. The image is laid out as though the device had no bad blocks, so image block `n` would normally sit in physical block `n`. Partition by partition, the mapper asks an external bad-block lookup about each physical block in turn. For every block it emits one command: program an image block into it, or skip it because it is bad.

A bad block shifts the rest of the partition's image forward by one block. The spare blocks at the end of a partition absorb these shifts, so no data ever spills past the partition's last block. The image blocks that no longer fit are announced as discarded once the partition's blocks have all been visited. Good blocks left over after the required image has been placed are still programmed with the padding or marker content that follows in the image. If a partition holds fewer good blocks than its image needs, the device is flagged as rejected. A one-cycle done pulse ends the plan.

Top module: `nand_skip_mapper`

## Requirements
- R1: After `start_i`, table entries are visited in index order, and entries whose valid bit is 0 are skipped. The table is expected to list partitions in ascending order of first block. Within an entry, every block from first to last is looked up exactly once, in ascending order. The lookup pulses `bb_rd_o` with `bb_addr_o`, and `bb_bad_i` must answer for that block on the following cycle.
- R2: A good block produces a command with action code 0 (program). Its image field is the partition's first block plus the number of good blocks already seen in that partition, and its physical field is the block itself. This holds also for free good blocks beyond the required image size.
- R3: A bad block produces a command with action code 1 (skip) and its own block as the physical field. The image field carries the image block still pending, and that index does not advance.
- R4: After the last block of a partition, one command with action code 2 (discard) is sent for each bad block found there. The image fields run in ascending order from the first unplaced image block up to the partition's last block, and the physical field carries the partition's last block.
- R5: The first image block of every partition is that partition's own first block, whatever bad blocks occurred in earlier partitions.
- R6: `reject_o` rises when a partition's good-block count is below its required size. It then stays high until the next accepted `start_i`, which clears it.
- R7: A single-block partition of required size one rejects the device exactly when that block is bad.
- R8: A command stays valid with unchanged fields until `cmd_ready_i` takes it. No command is lost or repeated under any pattern of backpressure.
- R9: `done_o` pulses for one cycle after the last command of the last entry, with `busy_o` low at that point. By then `reject_o` holds the final verdict.
- R10: `start_i` asserted while `busy_o` is high is ignored, and the command stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a plan over the table (taken only while idle) |
| part_valid_i | input | NPART | Per-entry used bit |
| part_first_i | input | NPART*BLK_W | Per-entry first physical block |
| part_last_i | input | NPART*BLK_W | Per-entry last physical block |
| part_need_i | input | NPART*(BLK_W+1) | Per-entry required good-block count |
| bb_rd_o | output | 1 | Bad-block lookup strobe |
| bb_addr_o | output | BLK_W | Block being looked up |
| bb_bad_i | input | 1 | Lookup answer, one cycle after the strobe |
| cmd_valid_o | output | 1 | Command available |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_act_o | output | 2 | 0 program, 1 skip, 2 discard |
| cmd_img_o | output | BLK_W | Image block index |
| cmd_phys_o | output | BLK_W | Physical block index |
| busy_o | output | 1 | Plan in progress |
| done_o | output | 1 | One-cycle end-of-plan pulse |
| reject_o | output | 1 | Device cannot hold the image |

## Verification
Each sweep walks one partition table through the empty bad map, the fully bad map, every single-bad-block map and pseudo-random maps, all under random backpressure. A mapper that advanced the image index on a bad block would program shifted data one block too early, and one that carried shift across partitions would start a later partition at the wrong image block. The sweeps also probe three other mistakes. A mapper that counted discards wrongly, or let a partition's data pass its last block, would emit too many or too few commands. A mapper that tested the good count with the wrong comparison would wrongly reject or accept a partition with no padding, including the one-block boot partition. A second start in the middle of a run checks that the run is not restarted, and the next start is checked to clear a sticky reject.

// File: rtl/nand_skip_pkg.sv
package nand_skip_pkg;

  typedef enum logic [1:0] {
    ACT_PROG = 2'd0,
    ACT_SKIP = 2'd1,
    ACT_DISC = 2'd2
  } map_act_e;

  typedef enum logic [2:0] {
    W_IDLE  = 3'd0,
    W_FETCH = 3'd1,
    W_QREQ  = 3'd2,
    W_QWAIT = 3'd3,
    W_EMIT  = 3'd4,
    W_DISC  = 3'd5,
    W_DEMIT = 3'd6,
    W_CHECK = 3'd7
  } walk_st_e;

endpackage

// File: rtl/map_entry_mux.sv
module map_entry_mux #(
  parameter int NPART = 8,
  parameter int BLK_W = 10,
  localparam int IDX_W = (NPART > 1) ? $clog2(NPART) : 1
) (
  input  logic [NPART-1:0]         valid_i,
  input  logic [NPART*BLK_W-1:0]   first_i,
  input  logic [NPART*BLK_W-1:0]   last_i,
  input  logic [NPART*(BLK_W+1)-1:0] need_i,
  input  logic [IDX_W-1:0]         sel_i,
  output logic                     ent_valid_o,
  output logic [BLK_W-1:0]         ent_first_o,
  output logic [BLK_W-1:0]         ent_last_o,
  output logic [BLK_W:0]           ent_need_o
);

  logic [BLK_W-1:0] first_a [NPART];
  logic [BLK_W-1:0] last_a  [NPART];
  logic [BLK_W:0]   need_a  [NPART];

  for (genvar g = 0; g < NPART; g++) begin : g_unpack
    assign first_a[g] = first_i[g*BLK_W +: BLK_W];
    assign last_a[g]  = last_i[g*BLK_W +: BLK_W];
    assign need_a[g]  = need_i[g*(BLK_W+1) +: (BLK_W+1)];
  end

  always_comb begin
    ent_valid_o = 1'b0;
    ent_first_o = '0;
    ent_last_o  = '0;
    ent_need_o  = '0;
    for (int k = 0; k < NPART; k++) begin
      if (sel_i == IDX_W'(k)) begin
        ent_valid_o = valid_i[k];
        ent_first_o = first_a[k];
        ent_last_o  = last_a[k];
        ent_need_o  = need_a[k];
      end
    end
  end

endmodule

// File: rtl/map_cmd_reg.sv
module map_cmd_reg #(
  parameter int BLK_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [1:0]       act_i,
  input  logic [BLK_W-1:0] img_i,
  input  logic [BLK_W-1:0] phys_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [1:0]       act_o,
  output logic [BLK_W-1:0] img_o,
  output logic [BLK_W-1:0] phys_o,
  output logic             fire_o
);

  assign fire_o = valid_o & ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      act_o   <= '0;
      img_o   <= '0;
      phys_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      act_o   <= act_i;
      img_o   <= img_i;
      phys_o  <= phys_i;
    end else if (fire_o) begin
      valid_o <= 1'b0;
    end
  end

  // R8: an offered command is held unchanged until it is taken
  p_hold_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(act_o) && $stable(img_o) && $stable(phys_o)));

  // R8: a new command is never loaded over one still pending
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !valid_o);

endmodule

// File: rtl/map_walker.sv
module map_walker
  import nand_skip_pkg::*;
#(
  parameter int NPART = 8,
  parameter int BLK_W = 10,
  localparam int IDX_W = (NPART > 1) ? $clog2(NPART) : 1,
  localparam int CNT_W = $clog2(NPART + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic [IDX_W-1:0] sel_o,
  input  logic             ent_valid_i,
  input  logic [BLK_W-1:0] ent_first_i,
  input  logic [BLK_W-1:0] ent_last_i,
  input  logic [BLK_W:0]   ent_need_i,
  output logic             bb_rd_o,
  output logic [BLK_W-1:0] bb_addr_o,
  input  logic             bb_bad_i,
  output logic             load_o,
  output logic [1:0]       act_o,
  output logic [BLK_W-1:0] img_o,
  output logic [BLK_W-1:0] phys_o,
  input  logic             fire_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             reject_o
);

  walk_st_e         st;
  logic [CNT_W-1:0] idx;
  logic [BLK_W-1:0] cur_first, cur_last, phys;
  logic [BLK_W:0]   cur_need, good, disc_img;
  logic [BLK_W:0]   pend_img;
  logic             table_end;

  assign sel_o     = idx[IDX_W-1:0];
  assign table_end = (idx == CNT_W'(NPART));
  assign pend_img  = {1'b0, cur_first} + good;
  assign bb_addr_o = phys;
  assign bb_rd_o   = (st == W_QREQ);
  assign busy_o    = (st != W_IDLE);

  always_comb begin
    load_o = 1'b0;
    act_o  = ACT_PROG;
    img_o  = pend_img[BLK_W-1:0];
    phys_o = phys;
    if (st == W_QWAIT) begin
      load_o = 1'b1;
      act_o  = bb_bad_i ? ACT_SKIP : ACT_PROG;
    end else if (st == W_DISC && disc_img <= {1'b0, cur_last}) begin
      load_o = 1'b1;
      act_o  = ACT_DISC;
      img_o  = disc_img[BLK_W-1:0];
      phys_o = cur_last;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      idx       <= '0;
      cur_first <= '0;
      cur_last  <= '0;
      cur_need  <= '0;
      phys      <= '0;
      good      <= '0;
      disc_img  <= '0;
      done_o    <= 1'b0;
      reject_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        W_IDLE: begin
          if (start_i) begin
            idx      <= '0;
            reject_o <= 1'b0;
            st       <= W_FETCH;
          end
        end
        W_FETCH: begin
          if (table_end) begin
            done_o <= 1'b1;
            st     <= W_IDLE;
          end else if (ent_valid_i) begin
            cur_first <= ent_first_i;
            cur_last  <= ent_last_i;
            cur_need  <= ent_need_i;
            phys      <= ent_first_i;
            good      <= '0;
            st        <= W_QREQ;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        W_QREQ:  st <= W_QWAIT;
        W_QWAIT: begin
          if (!bb_bad_i) good <= good + 1'b1;
          st <= W_EMIT;
        end
        W_EMIT: begin
          if (fire_i) begin
            if (phys == cur_last) begin
              disc_img <= pend_img;
              st       <= W_DISC;
            end else begin
              phys <= phys + 1'b1;
              st   <= W_QREQ;
            end
          end
        end
        W_DISC: begin
          if (disc_img > {1'b0, cur_last}) st <= W_CHECK;
          else                             st <= W_DEMIT;
        end
        W_DEMIT: begin
          if (fire_i) begin
            disc_img <= disc_img + 1'b1;
            st       <= W_DISC;
          end
        end
        W_CHECK: begin
          if (good < cur_need) reject_o <= 1'b1;
          idx <= idx + 1'b1;
          st  <= W_FETCH;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R1: lookups stay inside the current partition
  p_query_range_r1: assert property (@(posedge clk) disable iff (rst)
    bb_rd_o |-> (phys >= cur_first && phys <= cur_last));

  // R4: discards never pass the partition's last block
  p_disc_window_r4: assert property (@(posedge clk) disable iff (rst)
    (st == W_DEMIT) |-> (disc_img <= {1'b0, cur_last}));

  // R9: done is a single-cycle pulse taken while idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

endmodule

// File: rtl/nand_skip_mapper.sv
module nand_skip_mapper
  import nand_skip_pkg::*;
#(
  parameter int NPART = 8,
  parameter int BLK_W = 10,
  localparam int IDX_W = (NPART > 1) ? $clog2(NPART) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [NPART-1:0]           part_valid_i,
  input  logic [NPART*BLK_W-1:0]     part_first_i,
  input  logic [NPART*BLK_W-1:0]     part_last_i,
  input  logic [NPART*(BLK_W+1)-1:0] part_need_i,
  output logic                       bb_rd_o,
  output logic [BLK_W-1:0]           bb_addr_o,
  input  logic                       bb_bad_i,
  output logic                       cmd_valid_o,
  input  logic                       cmd_ready_i,
  output logic [1:0]                 cmd_act_o,
  output logic [BLK_W-1:0]           cmd_img_o,
  output logic [BLK_W-1:0]           cmd_phys_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       reject_o
);

  logic [IDX_W-1:0] sel;
  logic             ent_valid;
  logic [BLK_W-1:0] ent_first, ent_last;
  logic [BLK_W:0]   ent_need;
  logic             load, fire;
  logic [1:0]       w_act;
  logic [BLK_W-1:0] w_img, w_phys;

  map_entry_mux #(.NPART(NPART), .BLK_W(BLK_W)) u_mux (
    .valid_i(part_valid_i), .first_i(part_first_i), .last_i(part_last_i),
    .need_i(part_need_i), .sel_i(sel), .ent_valid_o(ent_valid),
    .ent_first_o(ent_first), .ent_last_o(ent_last), .ent_need_o(ent_need)
  );

  map_walker #(.NPART(NPART), .BLK_W(BLK_W)) u_walk (
    .clk(clk), .rst(rst), .start_i(start_i), .sel_o(sel),
    .ent_valid_i(ent_valid), .ent_first_i(ent_first), .ent_last_i(ent_last),
    .ent_need_i(ent_need), .bb_rd_o(bb_rd_o), .bb_addr_o(bb_addr_o),
    .bb_bad_i(bb_bad_i), .load_o(load), .act_o(w_act), .img_o(w_img),
    .phys_o(w_phys), .fire_i(fire), .busy_o(busy_o), .done_o(done_o),
    .reject_o(reject_o)
  );

  map_cmd_reg #(.BLK_W(BLK_W)) u_cmd (
    .clk(clk), .rst(rst), .load_i(load), .act_i(w_act), .img_i(w_img),
    .phys_i(w_phys), .ready_i(cmd_ready_i), .valid_o(cmd_valid_o),
    .act_o(cmd_act_o), .img_o(cmd_img_o), .phys_o(cmd_phys_o), .fire_o(fire)
  );

  // R2: programmed data only ever shifts toward higher blocks
  p_img_behind_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && cmd_act_o == 2'd0) |-> (cmd_img_o <= cmd_phys_o));

  // R6: reject is sticky until a start is taken from idle
  p_reject_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (reject_o && !(start_i && !busy_o)) |=> reject_o);

  // R10: a start during a run does not end the run
  p_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !done_o && cmd_valid_o) |=> busy_o);

  // R8: no code beyond discard appears
  p_act_code_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> (cmd_act_o != 2'd3));

endmodule

// File: tb/sim_nand_skip_mapper.sv
module sim_nand_skip_mapper;
  localparam int NP = 4;
  localparam int BW = 5;
  localparam int NB = 1 << BW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic                  start = 1'b0;
  logic [NP-1:0]         pv;
  logic [NP*BW-1:0]      pf, pl;
  logic [NP*(BW+1)-1:0]  pn;
  logic                  bb_rd, bb_bad = 1'b0;
  logic [BW-1:0]         bb_addr;
  logic                  cv, cr = 1'b0;
  logic [1:0]            ca;
  logic [BW-1:0]         ci, cp;
  logic                  busy, done, rej;

  int tv [NP];
  int tf [NP];
  int tl [NP];
  int tn [NP];
  logic [NB-1:0] badmap = '0;

  for (genvar g = 0; g < NP; g++) begin : g_tab
    assign pv[g]                   = tv[g] != 0;
    assign pf[g*BW +: BW]          = BW'(tf[g]);
    assign pl[g*BW +: BW]          = BW'(tl[g]);
    assign pn[g*(BW+1) +: (BW+1)]  = (BW+1)'(tn[g]);
  end

  always_ff @(posedge clk) bb_bad <= badmap[bb_addr];

  nand_skip_mapper #(.NPART(NP), .BLK_W(BW)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .part_valid_i(pv),
    .part_first_i(pf), .part_last_i(pl), .part_need_i(pn),
    .bb_rd_o(bb_rd), .bb_addr_o(bb_addr), .bb_bad_i(bb_bad),
    .cmd_valid_o(cv), .cmd_ready_i(cr), .cmd_act_o(ca), .cmd_img_o(ci),
    .cmd_phys_o(cp), .busy_o(busy), .done_o(done), .reject_o(rej)
  );

  int nvec = 0;
  int nbad = 0;
  int ea [256];
  int ei [256];
  int ep [256];
  int en;
  int erej;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic void build_exp();
    en = 0; erej = 0;
    for (int e = 0; e < NP; e++) begin
      int g;
      if (tv[e] == 0) continue;
      g = 0;
      for (int p = tf[e]; p <= tl[e]; p++) begin
        ea[en] = badmap[p] ? 1 : 0; ei[en] = tf[e] + g; ep[en] = p; en++;
        if (!badmap[p]) g++;
      end
      for (int i = tf[e] + g; i <= tl[e]; i++) begin
        ea[en] = 2; ei[en] = i; ep[en] = tl[e]; en++;
      end
      if (g < tn[e]) erej = 1;
    end
  endfunction

  function automatic void step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endfunction

  task automatic run_case(input logic [NB-1:0] bm, input bit poke);
    int k;
    int cyc;
    bit fin;
    badmap = bm;
    build_exp();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(rej == 1'b0, "R6", "reject cleared by start", rej, 0);
    k = 0; fin = 0;
    for (cyc = 0; cyc < 3000 && !fin; cyc++) begin
      @(negedge clk);
      step_lfsr();
      cr = lfsr[0] | lfsr[3];
      start = (poke && cyc == 7);   // R10: start while busy
      if (cv && cr) begin
        if (k < en) begin
          string rq;
          rq = (ea[k] == 0) ? "R2 R5" : (ea[k] == 1) ? "R3 R1" : "R4";
          if (poke) rq = {rq, " R10"};
          chk(ca == 2'(ea[k]), rq, "action", ca, ea[k]);
          chk(ci == BW'(ei[k]), rq, "image block", ci, ei[k]);
          chk(cp == BW'(ep[k]), rq, "physical block", cp, ep[k]);
        end else begin
          chk(1'b0, "R8", "extra command", k, en);
        end
        k++;
      end
      if (done) fin = 1;
    end
    start = 1'b0;
    chk(fin, "R9", "done seen", fin, 1);
    chk(k == en, "R8 R9", "command count", k, en);
    chk(!busy, "R9", "idle at done", busy, 0);
    chk(rej == erej[0], (bm[0] && tn[0] == 1) ? "R7 R6" : "R6",
        "reject", rej, erej);
    @(negedge clk);
    chk(!done, "R9", "done one cycle", done, 0);
    chk(rej == erej[0], "R6", "reject sticky", rej, erej);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 190000; wd++) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", wd, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    tv = '{1, 1, 0, 1}; tf = '{0, 1, 9, 12}; tl = '{0, 8, 11, 31}; tn = '{1, 6, 3, 15};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cv && !busy && !done && !rej, "R1", "reset state",
        {cv, busy, done, rej}, 0);
    run_case('0, 1'b0);
    run_case('1, 1'b0);
    for (int b = 0; b < NB; b++) run_case(NB'(1) << b, b[0]);
    for (int r = 0; r < 30; r++) begin
      logic [NB-1:0] m;
      step_lfsr(); m[15:0] = lfsr & {lfsr[7:0], lfsr[15:8]};
      step_lfsr(); m[31:16] = lfsr & {lfsr[3:0], lfsr[15:4]};
      run_case(m, r[1]);
    end
    tv = '{1, 1, 0, 1}; tf = '{0, 4, 0, 16}; tl = '{3, 15, 0, 23}; tn = '{4, 10, 1, 6};
    run_case('0, 1'b0);
    run_case(32'h0000_0004, 1'b0);
    run_case(32'h0000_0830, 1'b1);
    run_case(32'h0000_1830, 1'b0);
    run_case(32'h00C3_0000, 1'b0);
    run_case(32'h0007_0000, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule